// File: doc/BRIEF.md
# Three-wire serial byte engine

This block moves one byte at a time over a synchronous three-wire link: a reset-enable line, a link clock and a single bidirectional data line. A sequencer above it asks for one of three operations (open a transaction with a reset pulse, send a byte, or receive a byte). The engine then produces every edge on the link from an internal phase timer and reports completion with a one-cycle done pulse. Command bytes, addresses and the remote storage are the sequencer's business; the engine only shifts bits.

Bytes travel least-significant bit first. A sent bit is placed on the data line one phase before the link clock rises, held through the high phase and through the following low phase. A received bit is sampled at the end of a low phase, just before the engine raises the clock. The data line appears as separate enable, value and input signals so that it can drive a tristate pad, and the input passes through a parameterised synchroniser before it is sampled.

Top module: `twire_byte_engine`

## Requirements
- R1: While rst_n is low the engine shows busy=0, done=0, rd_data=0, the reset-enable line at its inactive level (high by default), link clock high, data enable low and data value high.
- R2: op code 0 (reset) asserts the reset-enable line (low by default) for exactly RSE_HOLD_CYC cycles with the data enable low, then releases it while driving link clock low, data enable high and data value low; done follows PHASE_CYC cycles later, RSE_HOLD_CYC+PHASE_CYC+1 cycles after the accepted start.
- R3: In the cycle after an accepted op code 1 (write) the data enable and data value are both high and the link clock is low.
- R4: A write sends bit 0 first and bit DATA_W-1 last; each bit is stable from one phase before the clock rises until the clock has fallen and a further phase has passed, the clock stays high PHASE_CYC cycles per bit, and done arrives 3*DATA_W*PHASE_CYC+2 cycles after start.
- R5: op code 2 (read) keeps the data enable low throughout, samples the data line at the end of each low phase into bit positions 0 upward, leaves the link clock high, and raises done 2*DATA_W*PHASE_CYC+1 cycles after start.
- R6: done is high for exactly one cycle per operation; rd_data takes the received byte in that cycle and otherwise holds its value, including across reset and write operations.
- R7: start is ignored while busy is high; the operation in progress keeps its timing and data.
- R8: op code 3 is ignored: busy stays low and no link line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only when idle |
| op | input | 2 | Operation: 0 reset pulse, 1 write byte, 2 read byte, 3 none |
| wr_data | input | DATA_W | Byte to send on a write |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Last received byte, updated with done |
| lnk_rse | output | 1 | Reset-enable line |
| lnk_clk | output | 1 | Link clock |
| lnk_oe | output | 1 | Data line output enable |
| lnk_do | output | 1 | Data line driven value |
| lnk_di | input | 1 | Data line sensed value |

## Verification
Writes are tried with alternating patterns (A5, 5A), a lone low bit (01) and a lone high bit (80); a swapped bit order or a missed shift shows up on the single-bit bytes, while the alternating bytes expose a value that is sampled a phase early or late. Reads are tried with all-ones, all-zeros, 3C and 96, so a stuck synchroniser, a reversed fill direction or an off-by-one bit count each give a different wrong byte. Latency is measured per operation to separate the reset, write and read phase counts, and mid-operation and invalid-code starts confirm that only idle, valid requests are taken.

// File: rtl/tw_pkg.sv
package tw_pkg;

   typedef enum logic [1:0] {
      TW_OP_RESET = 2'd0,
      TW_OP_WRITE = 2'd1,
      TW_OP_READ  = 2'd2,
      TW_OP_NONE  = 2'd3
   } tw_op_e;

   typedef enum logic [3:0] {
      S_IDLE    = 4'd0,
      S_RHOLD   = 4'd1,
      S_RSETTLE = 4'd2,
      S_WPRE    = 4'd3,
      S_WSETUP  = 4'd4,
      S_WHIGH   = 4'd5,
      S_WLOW    = 4'd6,
      S_RLOW    = 4'd7,
      S_RHIGH   = 4'd8
   } tw_state_e;

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   // A phase loaded with N-1 ends on the Nth edge after the load.
   assign expired = (cnt == '0);

endmodule

// File: rtl/tw_din_sync.sv
module tw_din_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else if (STAGES == 1) begin : g_one
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 1'b1;
            else        q <= din;
         end
         assign dout = q;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], din};
         end
         assign dout = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         ser_in,
   output logic [W-1:0] q
);

   // Right shift: bit 0 leaves first, new bits enter at the top.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= load_val;
      end else if (shift) begin
         q <= {ser_in, q[W-1:1]};
      end
   end

endmodule

// File: rtl/twire_byte_engine.sv
module twire_byte_engine
   import tw_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned PHASE_CYC      = 1250,
   parameter int unsigned RSE_HOLD_CYC   = 125000,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          RSE_ACTIVE_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic              lnk_rse,
   output logic              lnk_clk,
   output logic              lnk_oe,
   output logic              lnk_do,
   input  logic              lnk_di
);

   localparam int unsigned MAX_CYC = (RSE_HOLD_CYC > PHASE_CYC) ? RSE_HOLD_CYC : PHASE_CYC;
   localparam int unsigned TMR_W   = $clog2(MAX_CYC + 1);
   localparam int unsigned BIT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [TMR_W-1:0] PH_LD    = TMR_W'(PHASE_CYC - 1);
   localparam logic [TMR_W-1:0] RS_LD    = TMR_W'(RSE_HOLD_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (PHASE_CYC == 0 || RSE_HOLD_CYC == 0) begin : g_bad_len
         $error("phase and hold lengths must be non-zero");
      end
      if (PHASE_CYC <= SYNC_STAGES) begin : g_bad_sync
         $error("PHASE_CYC must exceed SYNC_STAGES so sampled data is settled");
      end
      if (SYNC_STAGES > 4) begin : g_bad_stages
         $error("SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   tw_state_e         state;
   logic              tmr_load;
   logic [TMR_W-1:0]  tmr_val;
   logic              tmr_exp;
   logic              sh_load;
   logic              sh_shift;
   logic [DATA_W-1:0] sh_val;
   logic [DATA_W-1:0] sh_q;
   logic              din_s;
   logic [BIT_W-1:0]  bcnt;
   logic              last_bit;
   logic              rse_act;

   tw_phase_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   tw_din_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (lnk_di),
      .dout  (din_s)
   );

   tw_shifter #(.W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .load_val (sh_val),
      .shift    (sh_shift),
      .ser_in   (din_s),
      .q        (sh_q)
   );

   assign last_bit = (bcnt == LAST_BIT);
   assign busy     = (state != S_IDLE);

   generate
      if (RSE_ACTIVE_LOW) begin : g_rse_low
         assign lnk_rse = ~rse_act;
      end else begin : g_rse_high
         assign lnk_rse = rse_act;
      end
   endgenerate

   // Timer and shifter controls, decided from the current state.
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = PH_LD;
      sh_load  = 1'b0;
      sh_val   = wr_data;
      sh_shift = 1'b0;
      case (state)
         S_IDLE: begin
            if (start) begin
               if (op == TW_OP_RESET) begin
                  tmr_load = 1'b1;
                  tmr_val  = RS_LD;
               end else if (op == TW_OP_WRITE) begin
                  sh_load = 1'b1;
               end else if (op == TW_OP_READ) begin
                  tmr_load = 1'b1;
                  sh_load  = 1'b1;
                  sh_val   = '0;
               end
            end
         end
         S_RHOLD, S_WSETUP, S_WHIGH: tmr_load = tmr_exp;
         S_WPRE: tmr_load = 1'b1;
         S_WLOW: begin
            if (tmr_exp && !last_bit) begin
               tmr_load = 1'b1;
               sh_shift = 1'b1;
            end
         end
         S_RLOW: begin
            if (tmr_exp) begin
               tmr_load = 1'b1;
               sh_shift = 1'b1;
            end
         end
         S_RHIGH: tmr_load = tmr_exp && !last_bit;
         default: ;
      endcase
   end

   // Sequencer and link line registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         done    <= 1'b0;
         rd_data <= '0;
         bcnt    <= '0;
         rse_act <= 1'b0;
         lnk_clk <= 1'b1;
         lnk_oe  <= 1'b0;
         lnk_do  <= 1'b1;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (start) begin
                  if (op == TW_OP_RESET) begin
                     rse_act <= 1'b1;
                     lnk_oe  <= 1'b0;
                     state   <= S_RHOLD;
                  end else if (op == TW_OP_WRITE) begin
                     lnk_oe  <= 1'b1;
                     lnk_do  <= 1'b1;
                     lnk_clk <= 1'b0;
                     bcnt    <= '0;
                     state   <= S_WPRE;
                  end else if (op == TW_OP_READ) begin
                     lnk_oe  <= 1'b0;
                     lnk_clk <= 1'b0;
                     bcnt    <= '0;
                     state   <= S_RLOW;
                  end
               end
            end
            S_RHOLD: begin
               if (tmr_exp) begin
                  rse_act <= 1'b0;
                  lnk_clk <= 1'b0;
                  lnk_oe  <= 1'b1;
                  lnk_do  <= 1'b0;
                  state   <= S_RSETTLE;
               end
            end
            S_RSETTLE: begin
               if (tmr_exp) begin
                  done  <= 1'b1;
                  state <= S_IDLE;
               end
            end
            S_WPRE: begin
               lnk_do <= sh_q[0];
               state  <= S_WSETUP;
            end
            S_WSETUP: begin
               if (tmr_exp) begin
                  lnk_clk <= 1'b1;
                  state   <= S_WHIGH;
               end
            end
            S_WHIGH: begin
               if (tmr_exp) begin
                  lnk_clk <= 1'b0;
                  state   <= S_WLOW;
               end
            end
            S_WLOW: begin
               if (tmr_exp) begin
                  if (last_bit) begin
                     done  <= 1'b1;
                     state <= S_IDLE;
                  end else begin
                     bcnt   <= bcnt + 1'b1;
                     lnk_do <= sh_q[1];
                     state  <= S_WSETUP;
                  end
               end
            end
            S_RLOW: begin
               if (tmr_exp) begin
                  lnk_clk <= 1'b1;
                  state   <= S_RHIGH;
               end
            end
            S_RHIGH: begin
               if (tmr_exp) begin
                  if (last_bit) begin
                     done    <= 1'b1;
                     rd_data <= sh_q;
                     state   <= S_IDLE;
                  end else begin
                     bcnt    <= bcnt + 1'b1;
                     lnk_clk <= 1'b0;
                     state   <= S_RLOW;
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/tw_engine_chk.sv
module tw_engine_chk #(
   parameter int unsigned DATA_W         = 8,
   parameter bit          RSE_ACTIVE_LOW = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [1:0]        op,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rd_data,
   input logic              lnk_rse,
   input logic              lnk_clk,
   input logic              lnk_oe,
   input logic              lnk_do
);

   logic rse_on;
   assign rse_on = RSE_ACTIVE_LOW ? !lnk_rse : lnk_rse;

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));

   // R6
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rd_data));

   // R2
   rse_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rse_on |-> !lnk_oe);

   // R4
   wr_bit_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lnk_oe && lnk_clk && $past(lnk_oe && lnk_clk)) |-> $stable(lnk_do));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (!start || op == 2'd3)) |=>
         ($stable(lnk_clk) && $stable(lnk_oe) && $stable(lnk_rse) && !busy));

endmodule

bind twire_byte_engine tw_engine_chk #(
   .DATA_W         (DATA_W),
   .RSE_ACTIVE_LOW (RSE_ACTIVE_LOW)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .busy    (busy),
   .done    (done),
   .rd_data (rd_data),
   .lnk_rse (lnk_rse),
   .lnk_clk (lnk_clk),
   .lnk_oe  (lnk_oe),
   .lnk_do  (lnk_do)
);

// File: tb/twire_byte_engine_test.sv
`timescale 1ns/1ps
module twire_byte_engine_test;

   localparam int P = 4;
   localparam int R = 20;
   localparam int S = 2;
   localparam int LAT_RST = R + P + 1;
   localparam int LAT_WR  = 24 * P + 2;
   localparam int LAT_RD  = 16 * P + 1;

   // {op, write byte, remote byte}
   localparam logic [17:0] VEC [0:7] = '{
      {2'd1, 8'hA5, 8'h00},
      {2'd2, 8'h00, 8'h3C},
      {2'd1, 8'h01, 8'h00},
      {2'd2, 8'h00, 8'hFF},
      {2'd1, 8'h80, 8'h00},
      {2'd2, 8'h00, 8'h00},
      {2'd1, 8'h5A, 8'h00},
      {2'd2, 8'h00, 8'h96}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op = 2'd0;
   logic [7:0] wr_data = 8'h00;
   logic       model_bit = 1'b1;
   wire        busy, done, lnk_rse, lnk_clk, lnk_oe, lnk_do;
   wire  [7:0] rd_data;
   wire        lnk_di;

   int n_chk = 0;
   int n_bad = 0;
   int lat, rlow, hi, oebad, ridx;
   logic [7:0] cap;
   logic first_oe, first_do, first_clk, prevc;

   always #4 clk = ~clk;

   assign lnk_di = lnk_oe ? lnk_do : model_bit;

   twire_byte_engine #(
      .DATA_W(8), .PHASE_CYC(P), .RSE_HOLD_CYC(R), .SYNC_STAGES(S), .RSE_ACTIVE_LOW(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_data(wr_data),
      .busy(busy), .done(done), .rd_data(rd_data),
      .lnk_rse(lnk_rse), .lnk_clk(lnk_clk), .lnk_oe(lnk_oe), .lnk_do(lnk_do), .lnk_di(lnk_di)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Issue one operation, act as the remote end, and measure the link.
   task automatic run_op(input logic [1:0] o, input logic [7:0] w, input logic [7:0] rb,
                         input int poke);
      @(negedge clk);
      start = 1'b1; op = o; wr_data = w;
      ridx = 0; model_bit = rb[0]; cap = 8'h00;
      rlow = 0; hi = 0; oebad = 0; prevc = lnk_clk;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (lat < 100000) begin
         lat++;
         if (lat == 1) begin
            first_oe = lnk_oe; first_do = lnk_do; first_clk = lnk_clk;
         end
         if (lat == poke) begin
            start = 1'b1; op = 2'd2; wr_data = 8'h00;
         end else begin
            start = 1'b0;
         end
         if (!lnk_rse) rlow++;
         if (lnk_clk && lnk_oe) hi++;
         if (o == 2'd2 && lnk_oe) oebad++;
         if (lnk_clk && !prevc) begin
            if (lnk_oe) cap = {lnk_do, cap[7:1]};
            else begin
               ridx++;
               model_bit = (ridx < 8) ? rb[ridx] : 1'b1;
            end
         end
         prevc = lnk_clk;
         if (done) break;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
      $finish;
   end

   initial begin
      logic [7:0] last_rd;
      logic snap_clk, snap_oe, snap_rse;
      repeat (3) @(negedge clk);
      // R1: values held during reset
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 rd_data", rd_data, 0);
      check("R1 rse", lnk_rse, 1);
      check("R1 clk", lnk_clk, 1);
      check("R1 oe", lnk_oe, 0);
      check("R1 do", lnk_do, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: reset pulse
      run_op(2'd0, 8'h00, 8'h00, 0);
      check("R2 latency", lat, LAT_RST);
      check("R2 hold cycles", rlow, R);
      check("R2 rse released", lnk_rse, 1);
      check("R2 clk low", lnk_clk, 0);
      check("R2 oe high", lnk_oe, 1);
      check("R2 do low", lnk_do, 0);
      check("R6 rd_data after reset op", rd_data, 0);
      @(negedge clk);
      check("R6 done width", done, 0);
      last_rd = 8'h00;

      for (int i = 0; i < 8; i++) begin
         logic [1:0] vo;
         logic [7:0] vw, vr;
         vo = VEC[i][17:16]; vw = VEC[i][15:8]; vr = VEC[i][7:0];
         run_op(vo, vw, vr, 0);
         if (vo == 2'd1) begin
            check("R3 first oe", first_oe, 1);
            check("R3 first do", first_do, 1);
            check("R3 first clk", first_clk, 0);
            check("R4 latency", lat, LAT_WR);
            check("R4 sent byte", cap, vw);
            check("R4 clock high cycles", hi, 8 * P);
            check("R6 rd_data held over write", rd_data, last_rd);
         end else begin
            check("R5 latency", lat, LAT_RD);
            check("R5 received byte", rd_data, vr);
            check("R5 oe stays low", oebad, 0);
            check("R5 clk ends high", lnk_clk, 1);
            last_rd = vr;
         end
         @(negedge clk);
         check("R6 done width", done, 0);
      end

      // R7: start while busy is ignored
      run_op(2'd1, 8'hC3, 8'h00, 10);
      check("R7 latency", lat, LAT_WR);
      check("R7 sent byte", cap, 8'hC3);
      check("R7 rd_data kept", rd_data, last_rd);
      @(negedge clk);
      check("R7 idle after", busy, 0);

      // R8: op code 3 does nothing
      snap_clk = lnk_clk; snap_oe = lnk_oe; snap_rse = lnk_rse;
      start = 1'b1; op = 2'd3; wr_data = 8'hFF;
      @(negedge clk);
      start = 1'b0;
      check("R8 busy", busy, 0);
      repeat (4) @(negedge clk);
      check("R8 busy later", busy, 0);
      check("R8 clk", lnk_clk, snap_clk);
      check("R8 oe", lnk_oe, snap_oe);
      check("R8 rse", lnk_rse, snap_rse);
      check("R8 done", done, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule